// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block keeps the pending flags and the enable bits for four interrupt sources of a small 8-bit controller core: an edge on one external port pin, a timer overflow pulse, a change on a group of watched port pins, and an analog-converter completion pulse. It combines them into a single interrupt request for the core and a wake request for use while the core is asleep.

The timer, external-pin and pin-change sources form the core group. Each of them has its own enable in the status/enable register. The converter source forms a peripheral group. It has its own enable and is further gated by a peripheral-group enable. A global enable gates every source.

Software reaches three byte-wide registers through a simple select/write/read interface. The core drives two pulses: one when it accepts an interrupt and one when it executes a return-from-interrupt. These clear and set the global enable. Vector fetch and return-address stacking stay in the core.

Top module: `intr_flag_ctrl`

## Requirements
- R1: While `rst_n` is low (synchronous power-on reset), the status/enable register (select 0), the peripheral flag register (select 1) and the peripheral enable register (select 2) all clear. Afterwards each reads 0x00, and `irq_req` and `wake_req` are low.
- R2: A one-cycle `warm_rst` pulse clears bits 7..1 of the status/enable register and bit 6 of both peripheral registers. Status bit 0 (pin-change flag) keeps its value.
- R3: The status/enable register stores all 8 written bits and reads them back. Its layout is: bit0 pin-change flag, bit1 external flag, bit2 timer flag, bit3 pin-change enable, bit4 external enable, bit5 timer enable, bit6 peripheral-group enable, bit7 global enable. The peripheral flag register (converter flag) and the peripheral enable register (converter enable) implement only bit 6. Their other bits read 0. Select 3 reads 0x00.
- R4: Status bit1 is set on an edge of `port_in[2]`. With `edge_rise`=1 the edge is low-to-high, with `edge_rise`=0 it is high-to-low. The opposite edge leaves bit1 unchanged.
- R5: Status bit0 is set in every cycle in which any of `port_in[0]`, `port_in[1]` or `port_in[3]` differs from a snapshot. The snapshot is taken at reset and on every cycle with `port_rd` high. Other port bits never set it.
- R6: A `tmr_ovf` pulse sets status bit2. An `adc_done` pulse sets bit 6 of the peripheral flag register.
- R7: Flags are set whatever the state of their enables. They stay set until software writes 0 to them. A hardware set in the same cycle as a software write of 0 leaves the flag set.
- R8: `irq_req` is high when the global enable is set and at least one source is pending. A core source is pending when its flag and its enable are both set. The converter source is pending when its flag, its enable and the peripheral-group enable are all set.
- R9: An `irq_take` pulse clears the global enable, overriding a same-cycle `irq_ret` or register write. An `irq_ret` pulse sets the global enable, overriding a same-cycle register write.
- R10: `wake_req` is high when `sleeping` is high and at least one source is pending as in R8, whatever the global enable holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| warm_rst | input | 1 | Master-clear or watchdog reset pulse |
| reg_sel | input | 2 | Register select: 0 status/enable, 1 peripheral flags, 2 peripheral enables |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| port_in | input | 8 | Port input levels |
| port_rd | input | 1 | Port read strobe; refreshes the pin-change snapshot |
| edge_rise | input | 1 | External pin edge select: 1 rising, 0 falling |
| tmr_ovf | input | 1 | Timer overflow pulse |
| adc_done | input | 1 | Converter completion pulse |
| irq_take | input | 1 | Core has accepted an interrupt |
| irq_ret | input | 1 | Core executes return-from-interrupt |
| sleeping | input | 1 | Core is in sleep mode |
| irq_req | output | 1 | Interrupt request to the core |
| wake_req | output | 1 | Wake request while asleep |

## Verification
The bench sweeps every status byte against every converter flag/enable pair and both sleep states. A design that forgot the peripheral-group gate, or that tied wake to the global enable, would raise or drop a request in some of those 2048 combinations.

It drives each external edge in both polarities. A design with the polarity inverted would set the flag on the wrong edge.

It toggles the watched pins and the unwatched pins separately. It then shows that a flag cleared while the pins still differ from the snapshot sets again, and stays clear only after a port read refreshes the snapshot.

Same-cycle collisions are also exercised: a write of 0 against a timer pulse, take against return, and return against a write. A design with the wrong priority would lose a flag or leave the global enable in the wrong state.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_W = 8;
  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_PFLG = 2'd1;
  localparam logic [1:0] SEL_PEN  = 2'd2;

  // status/enable bit positions (order is decoded by software)
  localparam int B_CHG_F = 0;
  localparam int B_EXT_F = 1;
  localparam int B_TMR_F = 2;
  localparam int B_CHG_E = 3;
  localparam int B_EXT_E = 4;
  localparam int B_TMR_E = 5;
  localparam int B_PER_E = 6;
  localparam int B_GLB_E = 7;
  localparam int B_ADC   = 6;

  function automatic logic watch_changed(input logic [REG_W-1:0] cur,
                                         input logic [REG_W-1:0] snap,
                                         input logic [REG_W-1:0] mask);
    return |((cur ^ snap) & mask);
  endfunction

  function automatic logic edge_seen(input logic prev, input logic cur,
                                     input logic rise);
    return rise ? (!prev && cur) : (prev && !cur);
  endfunction

  function automatic logic any_pending(input logic [REG_W-1:0] st,
                                       input logic adc_f, input logic adc_e);
    logic core_hit;
    core_hit = (st[B_CHG_F] & st[B_CHG_E]) | (st[B_EXT_F] & st[B_EXT_E]) |
               (st[B_TMR_F] & st[B_TMR_E]);
    return core_hit | (adc_f & adc_e & st[B_PER_E]);
  endfunction
endpackage

// File: rtl/intc_pin_watch.sv
module intc_pin_watch
  import intc_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] WATCH_MASK = 8'h0B,
  parameter int EXT_PIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_in,
  input  logic              port_rd,
  input  logic              edge_rise,
  output logic              chg_evt,
  output logic              ext_evt
);
  logic [PORT_W-1:0] snap_q;
  logic              ext_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q     <= port_in;
      ext_prev_q <= port_in[EXT_PIN];
    end else begin
      if (port_rd) snap_q <= port_in;
      ext_prev_q <= port_in[EXT_PIN];
    end
  end

  assign chg_evt = watch_changed(port_in, snap_q, WATCH_MASK);
  assign ext_evt = edge_seen(ext_prev_q, port_in[EXT_PIN], edge_rise);

  // R5: a port read leaves no difference against the new snapshot
  assert_snap_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && $stable(port_in)) |=> (!chg_evt || !$stable(port_in)));
endmodule

// File: rtl/intc_req_gate.sv
module intc_req_gate
  import intc_pkg::*;
(
  input  logic [REG_W-1:0] stat,
  input  logic             adc_f,
  input  logic             adc_e,
  input  logic             sleeping,
  output logic             pending,
  output logic             irq_req,
  output logic             wake_req
);
  assign pending  = any_pending(stat, adc_f, adc_e);
  assign irq_req  = pending & stat[B_GLB_E];
  assign wake_req = pending & sleeping;
endmodule

// File: rtl/intr_flag_ctrl.sv
module intr_flag_ctrl
  import intc_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] WATCH_MASK = 8'h0B,
  parameter int EXT_PIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [PORT_W-1:0] port_in,
  input  logic              port_rd,
  input  logic              edge_rise,
  input  logic              tmr_ovf,
  input  logic              adc_done,
  input  logic              irq_take,
  input  logic              irq_ret,
  input  logic              sleeping,
  output logic              irq_req,
  output logic              wake_req
);
  logic [REG_W-1:0] stat_q, stat_d;
  logic adc_f_q, adc_f_d, adc_e_q, adc_e_d;
  logic chg_evt, ext_evt, pending;
  logic wr_stat, wr_pflg, wr_pen;

  intc_pin_watch #(.PORT_W(PORT_W), .WATCH_MASK(WATCH_MASK), .EXT_PIN(EXT_PIN)) u_watch (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .port_rd(port_rd),
    .edge_rise(edge_rise), .chg_evt(chg_evt), .ext_evt(ext_evt));

  intc_req_gate u_gate (
    .stat(stat_q), .adc_f(adc_f_q), .adc_e(adc_e_q), .sleeping(sleeping),
    .pending(pending), .irq_req(irq_req), .wake_req(wake_req));

  assign wr_stat = reg_wr && (reg_sel == SEL_STAT);
  assign wr_pflg = reg_wr && (reg_sel == SEL_PFLG);
  assign wr_pen  = reg_wr && (reg_sel == SEL_PEN);

  always_comb begin
    stat_d = wr_stat ? reg_wdata : stat_q;
    stat_d[B_CHG_F] = stat_d[B_CHG_F] | chg_evt;
    stat_d[B_EXT_F] = stat_d[B_EXT_F] | ext_evt;
    stat_d[B_TMR_F] = stat_d[B_TMR_F] | tmr_ovf;
    if (irq_ret)  stat_d[B_GLB_E] = 1'b1;
    if (irq_take) stat_d[B_GLB_E] = 1'b0;
    adc_f_d = (wr_pflg ? reg_wdata[B_ADC] : adc_f_q) | adc_done;
    adc_e_d = wr_pen ? reg_wdata[B_ADC] : adc_e_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      adc_f_q <= 1'b0;
      adc_e_q <= 1'b0;
    end else if (warm_rst) begin
      stat_q  <= {{(REG_W-1){1'b0}}, stat_q[B_CHG_F]};
      adc_f_q <= 1'b0;
      adc_e_q <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      adc_f_q <= adc_f_d;
      adc_e_q <= adc_e_d;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_STAT: reg_rdata = stat_q;
      SEL_PFLG: reg_rdata = {1'b0, adc_f_q, 6'b0};
      SEL_PEN:  reg_rdata = {1'b0, adc_e_q, 6'b0};
      default:  reg_rdata = '0;
    endcase
  end

  assert_warm_keeps_chg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> (stat_q[REG_W-1:1] == '0) && (stat_q[B_CHG_F] == $past(stat_q[B_CHG_F])));
  assert_ext_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_evt && !warm_rst) |=> stat_q[B_EXT_F]);
  assert_chg_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_evt && !warm_rst) |=> stat_q[B_CHG_F]);
  assert_sources_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ovf && adc_done && !warm_rst) |=> (stat_q[B_TMR_F] && adc_f_q));
  assert_req_needs_global_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> stat_q[B_GLB_E]);
  assert_take_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !stat_q[B_GLB_E]);
  assert_ret_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_take && !warm_rst) |=> stat_q[B_GLB_E]);
  assert_wake_only_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (sleeping && pending));
endmodule

// File: tb/sim_intr_flag_ctrl.sv
`timescale 1ns/1ps
module sim_intr_flag_ctrl;
  logic clk = 1'b0;
  logic rst_n, warm_rst, reg_wr, port_rd, edge_rise, tmr_ovf, adc_done;
  logic irq_take, irq_ret, sleeping, irq_req, wake_req;
  logic [1:0] reg_sel;
  logic [7:0] reg_wdata, reg_rdata, port_in;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intr_flag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .port_in(port_in), .port_rd(port_rd), .edge_rise(edge_rise),
    .tmr_ovf(tmr_ovf), .adc_done(adc_done), .irq_take(irq_take),
    .irq_ret(irq_ret), .sleeping(sleeping), .irq_req(irq_req), .wake_req(wake_req));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs driven at the falling edge, taken at the next rising edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    reg_sel = s;
    #0.5 d = reg_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [1:0] s, input logic [7:0] exp);
    logic [7:0] v;
    rd(s, v);
    chk(req, v, exp);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; warm_rst = 0; reg_wr = 0; port_rd = 0; edge_rise = 1; tmr_ovf = 0;
    adc_done = 0; irq_take = 0; irq_ret = 0; sleeping = 0;
    reg_sel = 0; reg_wdata = 0; port_in = 8'h00;
    @(negedge clk); tick(); tick();
    rst_n = 1;
    // R1 reset state
    expect_reg("R1 stat", 2'd0, 8'h00);
    expect_reg("R1 pflg", 2'd1, 8'h00);
    expect_reg("R1 pen", 2'd2, 8'h00);
    chk("R1 irq_req", {7'b0, irq_req}, 8'h00);
    chk("R1 wake_req", {7'b0, wake_req}, 8'h00);

    // R3 register access
    wr(2'd1, 8'hFF); expect_reg("R3 pflg bit6 only", 2'd1, 8'h40);
    wr(2'd2, 8'hBF); expect_reg("R3 pen bit6 clear", 2'd2, 8'h00);
    wr(2'd2, 8'hFF); expect_reg("R3 pen bit6 only", 2'd2, 8'h40);
    wr(2'd0, 8'hA5); expect_reg("R3 stat", 2'd0, 8'hA5);
    expect_reg("R3 sel3", 2'd3, 8'h00);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);

    // R8 and R10 sweep
    for (int s = 0; s < 256; s++) begin
      for (int p = 0; p < 4; p++) begin
        logic pend;
        wr(2'd0, s[7:0]);
        wr(2'd1, p[0] ? 8'h40 : 8'h00);
        wr(2'd2, p[1] ? 8'h40 : 8'h00);
        pend = (s[0] & s[3]) | (s[1] & s[4]) | (s[2] & s[5]) | (s[6] & p[0] & p[1]);
        for (int sl = 0; sl < 2; sl++) begin
          sleeping = sl[0];
          #0.5;
          chk("R8 irq_req", {7'b0, irq_req}, {7'b0, s[7] & pend});
          chk("R10 wake_req", {7'b0, wake_req}, {7'b0, sl[0] & pend});
        end
        sleeping = 0;
      end
    end
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);

    // R4 external edge select
    edge_rise = 1; port_in[2] = 1; tick();
    expect_reg("R4 rising sets", 2'd0, 8'h02);
    wr(2'd0, 8'h00);
    port_in[2] = 0; tick();
    expect_reg("R4 falling ignored when rising", 2'd0, 8'h00);
    edge_rise = 0; port_in[2] = 1; tick();
    expect_reg("R4 rising ignored when falling", 2'd0, 8'h00);
    port_in[2] = 0; tick();
    expect_reg("R4 falling sets", 2'd0, 8'h02);
    wr(2'd0, 8'h00);

    // R5 pin change
    port_in[7:4] = 4'hF; tick(); tick();
    expect_reg("R5 unwatched pins", 2'd0, 8'h00);
    port_in[3] = 1; tick();
    expect_reg("R5 bit3 change", 2'd0, 8'h01);
    wr(2'd0, 8'h00);
    expect_reg("R5 resets while differing", 2'd0, 8'h01);
    port_rd = 1; tick(); port_rd = 0;
    wr(2'd0, 8'h00);
    expect_reg("R5 clear after snapshot", 2'd0, 8'h00);
    port_in[0] = 1; tick();
    expect_reg("R5 bit0 change", 2'd0, 8'h01);
    port_rd = 1; tick(); port_rd = 0; wr(2'd0, 8'h00);
    port_in[1] = 1; tick();
    expect_reg("R5 bit1 change", 2'd0, 8'h01);
    port_rd = 1; tick(); port_rd = 0; wr(2'd0, 8'h00);

    // R6 timer and converter
    tmr_ovf = 1; tick(); tmr_ovf = 0;
    expect_reg("R6 timer flag", 2'd0, 8'h04);
    adc_done = 1; tick(); adc_done = 0;
    expect_reg("R6 adc flag", 2'd1, 8'h40);

    // R7 flags hold, hardware set beats write of zero
    tick(); tick(); tick();
    expect_reg("R7 timer holds", 2'd0, 8'h04);
    expect_reg("R7 adc holds", 2'd1, 8'h40);
    reg_sel = 2'd0; reg_wdata = 8'h00; reg_wr = 1; tmr_ovf = 1;
    tick(); reg_wr = 0; tmr_ovf = 0;
    expect_reg("R7 set beats clear", 2'd0, 8'h04);
    reg_sel = 2'd1; reg_wdata = 8'h00; reg_wr = 1; adc_done = 1;
    tick(); reg_wr = 0; adc_done = 0;
    expect_reg("R7 adc set beats clear", 2'd1, 8'h40);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);

    // R9 global enable on entry and return
    wr(2'd0, 8'h80);
    irq_take = 1; tick(); irq_take = 0;
    expect_reg("R9 take clears", 2'd0, 8'h00);
    irq_ret = 1; tick(); irq_ret = 0;
    expect_reg("R9 ret sets", 2'd0, 8'h80);
    irq_take = 1; irq_ret = 1; tick(); irq_take = 0; irq_ret = 0;
    expect_reg("R9 take beats ret", 2'd0, 8'h00);
    reg_sel = 2'd0; reg_wdata = 8'h80; reg_wr = 1; irq_take = 1;
    tick(); reg_wr = 0; irq_take = 0;
    expect_reg("R9 take beats write", 2'd0, 8'h00);
    reg_sel = 2'd0; reg_wdata = 8'h00; reg_wr = 1; irq_ret = 1;
    tick(); reg_wr = 0; irq_ret = 0;
    expect_reg("R9 ret beats write", 2'd0, 8'h80);

    // R2 warm reset
    wr(2'd0, 8'hFF); wr(2'd1, 8'h40); wr(2'd2, 8'h40);
    warm_rst = 1; tick(); warm_rst = 0;
    expect_reg("R2 stat keeps bit0", 2'd0, 8'h01);
    expect_reg("R2 pflg", 2'd1, 8'h00);
    expect_reg("R2 pen", 2'd2, 8'h00);
    wr(2'd0, 8'hFE);
    warm_rst = 1; tick(); warm_rst = 0;
    expect_reg("R2 stat bit0 stays clear", 2'd0, 8'h00);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule